// File: doc/BRIEF.md
# Ethernet Speed and Duplex Resolver

This block chooses the operating mode of a 10/100 Ethernet PHY. When negotiation is enabled, it compares the local advertisement word with the ability word received from the link partner. It then picks the best mode that both ends support. If the partner does not negotiate, a link reported by one of the two link detectors settles the mode instead. This is parallel detection, and the block also writes a fixed ability word on the partner's behalf. When negotiation is disabled, two control bits force the speed and the duplex.

The block sits between the register file and the line-side state machines. It receives the control bits, the two 16-bit words, a strobe that marks a received partner page, the two link-detect levels and a restart pulse. It returns the applied mode, the completion, speed and duplex status bits, the partner word, a partner-can-negotiate flag and a parallel-detect fault flag. All outputs are registered and change one clock after the input that causes them.

Top module: `an_resolve`

## Requirements
- R1: The ability fields of both words are bit 8 for 100 Mb/s full duplex, bit 7 for 100 Mb/s half duplex, bit 6 for 10 Mb/s full duplex and bit 5 for 10 Mb/s half duplex. On a page strobe, the applied mode is the highest of these that is set in both words. The ranking from top to bottom is 100 full, 100 half, 10 full, 10 half.
- R2: If a received page shares no ability with the advertisement, `an_complete` stays 0, `mode_valid` stays 0 and no mode is applied.
- R3: A 100 Mb/s link detected without a page sets the partner word to 0x0081, applies 100 Mb/s half duplex, sets `an_complete` and clears `lp_an_able`.
- R4: A 10 Mb/s link detected without a page sets the partner word to 0x0021 and applies 10 Mb/s half duplex. It also sets `an_complete` and clears `lp_an_able`.
- R5: When both link detectors report at once during negotiation, `pd_fault` is set and `an_complete` stays 0 until the next restart.
- R6: With `ctrl_an_en` low, the mode follows `ctrl_speed100` (1 = 100 Mb/s) and `ctrl_full_dup` (1 = full). `mode_valid` is 1 and `an_complete` is 0.
- R7: While `ctrl_an_en` is high, `ctrl_speed100` and `ctrl_full_dup` have no effect on the applied mode.
- R8: `stat_speed10` (1 = 10 Mb/s) and `stat_full` (1 = full duplex) reflect the mode only when `mode_valid` is 1, and are 0 otherwise.
- R9: A `restart` pulse, a fall of the combined link indication, reset, or the turning on of `ctrl_an_en` each restart negotiation. A restart clears completion, the mode, the partner word, `lp_an_able` and `pd_fault`.
- R10: A page strobe stores the partner word as received and sets `lp_an_able`.
- R11: Once negotiation is complete, further page strobes and link indications change nothing until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_an_en | input | 1 | Negotiation enable |
| ctrl_speed100 | input | 1 | Forced speed, 1 = 100 Mb/s |
| ctrl_full_dup | input | 1 | Forced duplex, 1 = full |
| restart | input | 1 | Restart negotiation pulse |
| adv_word | input | 16 | Local advertisement word |
| page_word | input | 16 | Received partner page |
| page_rx | input | 1 | Strobe: page_word is valid |
| link10_det | input | 1 | 10 Mb/s link detector valid |
| link100_det | input | 1 | 100 Mb/s link detector valid |
| lp_word | output | 16 | Partner ability word |
| mode_valid | output | 1 | A mode is applied |
| mode_speed100 | output | 1 | Applied speed, 1 = 100 Mb/s |
| mode_full | output | 1 | Applied duplex, 1 = full |
| an_complete | output | 1 | Negotiation complete status |
| stat_speed10 | output | 1 | Speed status, 1 = 10 Mb/s |
| stat_full | output | 1 | Duplex status, 1 = full |
| lp_an_able | output | 1 | Partner negotiates |
| pd_fault | output | 1 | Parallel-detect fault |

## Verification
A wrong choice in the priority resolver shows on `mode_speed100` and `mode_full` one clock after the page strobe. The bench therefore feeds ability pairs whose best common mode differs at each ranking level. A completion flag that stays set after a restart or a link loss would freeze the mode. A later page would then be ignored, and this shows on `lp_word` one clock after that page. A missing clear of the forced mode when negotiation is turned on shows as `mode_valid` still high one clock after the enable.

// File: rtl/an_pkg.sv
// Shared definitions for the speed/duplex resolver.
// Assumes the ability fields sit in bits 8..5 of a 16-bit word.
package an_pkg;
    localparam int WORD_W   = 16;
    localparam int ABIL_LO  = 5;
    localparam int N_MODES  = 4;
    localparam int MODE_W   = $clog2(N_MODES);

    // Index equals rank: larger index means higher priority.
    typedef enum logic [MODE_W-1:0] {
        M_10_HALF  = 2'd0,
        M_10_FULL  = 2'd1,
        M_100_HALF = 2'd2,
        M_100_FULL = 2'd3
    } mode_t;

    function automatic logic mode_is_100(mode_t m);
        return m[1];
    endfunction

    function automatic logic mode_is_full(mode_t m);
        return m[0];
    endfunction
endpackage

// File: rtl/an_prio_pick.sv
// Picks the highest-ranked ability set in both words.
// Purely combinational; assumes ranking follows the bit index.
module an_prio_pick
    import an_pkg::*;
#(
    parameter int N = N_MODES,
    parameter int LO = ABIL_LO,
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    output logic         found,
    output mode_t        pick
);
    localparam int HI = LO + N - 1;

    logic [N-1:0] common;
    assign common = word_a[HI:LO] & word_b[HI:LO];

    // Scan upward so the last hit is the highest rank.
    always_comb begin
        found = 1'b0;
        pick  = M_10_HALF;
        for (int i = 0; i < N; i++) begin
            if (common[i]) begin
                found = 1'b1;
                pick  = mode_t'(i);
            end
        end
    end
endmodule

// File: rtl/an_link_watch.sv
// Watches the two link detectors: flags loss of any link and a
// simultaneous report from both. Assumes levels already synchronous.
module an_link_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic link10,
    input  logic link100,
    output logic link_lost,
    output logic both_up
);
    logic prev_up;
    logic any_up;

    assign any_up    = link10 | link100;
    assign link_lost = prev_up & ~any_up;
    assign both_up   = link10 & link100;

    // Remember the combined link level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_up <= 1'b0;
        else        prev_up <= any_up;
    end
endmodule

// File: rtl/an_resolve.sv
// Speed and duplex resolution for a 10/100 PHY: negotiated, parallel
// detected or forced. Assumes page_rx is a one-cycle strobe and that
// all inputs are synchronous to clk.
module an_resolve
    import an_pkg::*;
#(
    parameter logic [WORD_W-1:0] PD100_WORD = 16'h0081,
    parameter logic [WORD_W-1:0] PD10_WORD  = 16'h0021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_an_en,
    input  logic              ctrl_speed100,
    input  logic              ctrl_full_dup,
    input  logic              restart,
    input  logic [WORD_W-1:0] adv_word,
    input  logic [WORD_W-1:0] page_word,
    input  logic              page_rx,
    input  logic              link10_det,
    input  logic              link100_det,
    output logic [WORD_W-1:0] lp_word,
    output logic              mode_valid,
    output logic              mode_speed100,
    output logic              mode_full,
    output logic              an_complete,
    output logic              stat_speed10,
    output logic              stat_full,
    output logic              lp_an_able,
    output logic              pd_fault
);
    logic  found;
    mode_t pick;
    logic  link_lost;
    logic  both_up;
    logic  en_q;
    logic  done_q;
    logic  fault_q;
    logic  able_q;
    logic  valid_q;
    logic  spd_q;
    logic  full_q;
    logic [WORD_W-1:0] lp_q;
    logic  renegotiate;

    an_prio_pick u_pick (
        .word_a (adv_word),
        .word_b (page_word),
        .found  (found),
        .pick   (pick)
    );

    an_link_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .link10    (link10_det),
        .link100   (link100_det),
        .link_lost (link_lost),
        .both_up   (both_up)
    );

    assign renegotiate = restart | link_lost | ~en_q;

    // Track the enable so that turning it on restarts negotiation.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= ctrl_an_en;
    end

    // Main resolution state: forced, restart, page, parallel detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            able_q  <= 1'b0;
            valid_q <= 1'b0;
            spd_q   <= 1'b0;
            full_q  <= 1'b0;
            lp_q    <= '0;
        end else if (!ctrl_an_en) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            able_q  <= 1'b0;
            lp_q    <= '0;
            valid_q <= 1'b1;
            spd_q   <= ctrl_speed100;
            full_q  <= ctrl_full_dup;
        end else if (renegotiate) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            able_q  <= 1'b0;
            lp_q    <= '0;
            valid_q <= 1'b0;
            spd_q   <= 1'b0;
            full_q  <= 1'b0;
        end else if (!done_q && !fault_q) begin
            if (page_rx) begin
                lp_q   <= page_word;
                able_q <= 1'b1;
                if (found) begin
                    done_q  <= 1'b1;
                    valid_q <= 1'b1;
                    spd_q   <= mode_is_100(pick);
                    full_q  <= mode_is_full(pick);
                end
            end else if (both_up) begin
                fault_q <= 1'b1;
            end else if (link100_det) begin
                lp_q    <= PD100_WORD;
                able_q  <= 1'b0;
                done_q  <= 1'b1;
                valid_q <= 1'b1;
                spd_q   <= 1'b1;
                full_q  <= 1'b0;
            end else if (link10_det) begin
                lp_q    <= PD10_WORD;
                able_q  <= 1'b0;
                done_q  <= 1'b1;
                valid_q <= 1'b1;
                spd_q   <= 1'b0;
                full_q  <= 1'b0;
            end
        end
    end

    assign lp_word       = lp_q;
    assign mode_valid    = valid_q;
    assign mode_speed100 = spd_q;
    assign mode_full     = full_q;
    assign an_complete   = done_q;
    assign lp_an_able    = able_q;
    assign pd_fault      = fault_q;
    assign stat_speed10  = valid_q & ~spd_q;
    assign stat_full     = valid_q & full_q;

    AST_PD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (an_complete && !lp_an_able) |-> (lp_word == PD100_WORD || lp_word == PD10_WORD)); // R3
    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        pd_fault |-> !an_complete); // R5
    AST_FORCED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctrl_an_en)) |-> (mode_valid && !an_complete
            && mode_speed100 == $past(ctrl_speed100) && mode_full == $past(ctrl_full_dup))); // R6
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> (!stat_speed10 && !stat_full)); // R8
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!an_complete && !pd_fault)); // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (an_complete && ctrl_an_en && !restart && !link_lost) |=> ($stable(lp_word) && an_complete)); // R11
endmodule

// File: tb/an_resolve_test.sv
module an_resolve_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_an_en = 1'b1;
    logic        ctrl_speed100 = 1'b0;
    logic        ctrl_full_dup = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] adv_word = 16'h01E1;
    logic [15:0] page_word = 16'h0000;
    logic        page_rx = 1'b0;
    logic        link10_det = 1'b0;
    logic        link100_det = 1'b0;
    logic [15:0] lp_word;
    logic        mode_valid, mode_speed100, mode_full, an_complete;
    logic        stat_speed10, stat_full, lp_an_able, pd_fault;

    int checks = 0;
    int errors = 0;

    an_resolve uut (
        .clk(clk), .rst_n(rst_n), .ctrl_an_en(ctrl_an_en),
        .ctrl_speed100(ctrl_speed100), .ctrl_full_dup(ctrl_full_dup),
        .restart(restart), .adv_word(adv_word), .page_word(page_word),
        .page_rx(page_rx), .link10_det(link10_det), .link100_det(link100_det),
        .lp_word(lp_word), .mode_valid(mode_valid), .mode_speed100(mode_speed100),
        .mode_full(mode_full), .an_complete(an_complete), .stat_speed10(stat_speed10),
        .stat_full(stat_full), .lp_an_able(lp_an_able), .pd_fault(pd_fault)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled at negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_mode(input string req, input logic v, input logic s100,
                              input logic f, input logic done);
        check(req, "mode_valid", mode_valid, v);
        check(req, "mode_speed100", mode_speed100, s100);
        check(req, "mode_full", mode_full, f);
        check(req, "an_complete", an_complete, done);
        check(req, "stat_speed10", stat_speed10, v & ~s100);
        check(req, "stat_full", stat_full, v & f);
    endtask

    task automatic do_restart();
        link10_det = 0; link100_det = 0; page_rx = 0;
        restart = 1; step();
        restart = 0; step();
    endtask

    task automatic send_page(input logic [15:0] adv, input logic [15:0] lp);
        adv_word = adv; page_word = lp; page_rx = 1; step();
        page_rx = 0;
    endtask

    task automatic t_reset();
        check("R9", "reset lp_word", lp_word, 16'h0);
        check_mode("R9", 0, 0, 0, 0);
        check("R9", "reset fault", pd_fault, 0);
    endtask

    task automatic t_priority();
        do_restart(); send_page(16'h01E1, 16'h01E1);
        check_mode("R1", 1, 1, 1, 1);                // 100 full
        check("R10", "lp_word", lp_word, 16'h01E1);
        check("R10", "lp_an_able", lp_an_able, 1);
        do_restart(); send_page(16'h01E1, 16'h00E1);
        check_mode("R1", 1, 1, 0, 1);                // 100 half
        do_restart(); send_page(16'h0061, 16'h01E1);
        check_mode("R1", 1, 0, 1, 1);                // 10 full
        do_restart(); send_page(16'h0121, 16'h0021);
        check_mode("R1", 1, 0, 0, 1);                // 10 half
    endtask

    task automatic t_no_common();
        do_restart(); send_page(16'h0101, 16'h0041);
        check_mode("R2", 0, 0, 0, 0);
        check("R2", "lp_word stored", lp_word, 16'h0041);
    endtask

    task automatic t_pd();
        do_restart(); link100_det = 1; step();
        check("R3", "lp_word", lp_word, 16'h0081);
        check("R3", "lp_an_able", lp_an_able, 0);
        check_mode("R3", 1, 1, 0, 1);
        do_restart(); link10_det = 1; step();
        check("R4", "lp_word", lp_word, 16'h0021);
        check_mode("R4", 1, 0, 0, 1);
        link10_det = 0; step();                      // link loss restarts
        check_mode("R9", 0, 0, 0, 0);
        check("R9", "lp_word after loss", lp_word, 16'h0);
    endtask

    task automatic t_fault();
        do_restart(); link10_det = 1; link100_det = 1; step();
        check("R5", "pd_fault", pd_fault, 1);
        check("R5", "an_complete", an_complete, 0);
        step();
        check("R5", "held complete", an_complete, 0);
        restart = 1; step(); restart = 0;
        check("R9", "fault cleared", pd_fault, 0);
        link10_det = 0; link100_det = 0; step();
    endtask

    task automatic t_forced();
        ctrl_an_en = 0; ctrl_speed100 = 1; ctrl_full_dup = 0; step();
        check_mode("R6", 1, 1, 0, 0);
        ctrl_speed100 = 0; ctrl_full_dup = 1; step();
        check_mode("R6", 1, 0, 1, 0);
        check("R8", "stat_speed10", stat_speed10, 1);
        ctrl_an_en = 1; step();
        check_mode("R9", 0, 0, 0, 0);
    endtask

    task automatic t_ignored();
        do_restart();
        ctrl_speed100 = 1; ctrl_full_dup = 1;
        send_page(16'h0021, 16'h0021);
        check_mode("R7", 1, 0, 0, 1);
        ctrl_speed100 = 0; ctrl_full_dup = 0;
    endtask

    task automatic t_hold();
        do_restart(); send_page(16'h01E1, 16'h01E1);
        send_page(16'h01E1, 16'h0021);
        check("R11", "lp_word held", lp_word, 16'h01E1);
        check_mode("R11", 1, 1, 1, 1);
        link10_det = 1; link100_det = 1; step();
        check("R11", "no fault after done", pd_fault, 0);
        restart = 1; step(); restart = 0;
        check_mode("R9", 0, 0, 0, 0);
        link10_det = 0; link100_det = 0; step();
        send_page(16'h01E1, 16'h0041);
        check("R10", "new page after restart", lp_word, 16'h0041);
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_priority();
        t_no_common();
        t_pd();
        t_fault();
        t_forced();
        t_ignored();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule